// File: doc/BRIEF.md
# Dual-Role SPI Clock Edge Generator

This block produces the serial clock and the per-bit edge strobes for an SPI port that can work as either the clock owner (master) or the clock follower (slave). In master role it runs a small state machine. A `start` pulse begins a transfer, and each `baud_tick` from an external divider toggles `sck_out`. After sixteen half-periods, which is eight bits, the transfer stops and the clock rests at the polarity level. In slave role it brings the incoming `sck_in` into the system clock domain through a synchroniser. It then finds each edge by comparing the latest synchronised value with the one before it.

Both paths report each edge as leading (moving away from the rest level `cpol`) or trailing (moving back to it). A selector uses `role_mst` to pick which path is used. It uses `cpha` to map the edge kind onto a one-cycle `shift_stb` (drive the next outgoing bit) and a one-cycle `sample_stb` (capture the incoming bit). It also passes a `count_tick` to the transfer controller on every trailing edge.

The master state machine has two states. `M_IDLE` holds the clock at rest. The transition `M_IDLE -> M_RUN` occurs on `start` in master role. `M_RUN` toggles the clock on each baud tick. The transition `M_RUN -> M_IDLE` occurs on the baud tick that completes the sixteenth half-period.

Top module: `spi_edge_gen`

## Requirements
- R1: While reset is asserted and in the first cycles after release, `shift_stb`, `sample_stb` and `count_tick` are 0 and `sck_out` equals `cpol`, whatever level `sck_in` has.
- R2: In master role, while no transfer runs, `sck_out` equals `cpol`. A one-cycle `start` begins a transfer (`M_IDLE -> M_RUN`). Each `baud_tick` seen at a clock edge in `M_RUN` toggles `sck_out` in the cycle after that edge. The first toggle moves `sck_out` away from `cpol`.
- R3: A master transfer makes exactly 16 toggles (8 bits) and then returns to `M_IDLE`. Later baud ticks leave `sck_out` at `cpol` and raise no strobe.
- R4: In master role, each `sck_out` toggle is accompanied in the same cycle by one strobe. Toggles with an even index (0, 2, ...) are leading edges and toggles with an odd index are trailing edges.
- R5: Edge-to-strobe mapping: with `cpha`=0 a leading edge gives `sample_stb` and a trailing edge gives `shift_stb`. With `cpha`=1 a leading edge gives `shift_stb` and a trailing edge gives `sample_stb`.
- R6: Each strobe lasts exactly one system clock cycle, and `shift_stb` and `sample_stb` are never high together.
- R7: In slave role, `sck_in` passes through a two-flop synchroniser. After a change of `sck_in`, the strobe is high in the cycle that follows the second rising system clock edge after the change.
- R8: In slave role, a change of `sck_in` away from `cpol` counts as a leading edge and a change back to `cpol` counts as a trailing edge.
- R9: `count_tick` pulses together with every trailing-edge strobe, giving 8 pulses per master transfer, and at no other time.
- R10: Role selection: in master role, `sck_in` changes raise no strobe. In slave role, `start` and `baud_tick` have no effect, and `sck_out` stays at `cpol`.
- R11: A `start` pulse during a running transfer is ignored. The transfer still ends after exactly 16 toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_mst | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | Phase select for the edge-to-strobe mapping |
| start | input | 1 | One-cycle request to begin a master transfer |
| baud_tick | input | 1 | Half-period tick from the clock divider |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master role |
| shift_stb | output | 1 | One-cycle strobe: drive the next output bit |
| sample_stb | output | 1 | One-cycle strobe: capture the input bit |
| count_tick | output | 1 | One-cycle bit-complete tick for the transfer controller |

## Verification
The assertions assume that `cpol`, `cpha` and `role_mst` change only while the block is quiet: no transfer is running and no `sck_in` edge is still inside the synchroniser. If these inputs changed at any other time, an edge could be reclassified halfway, and that would break the single-cycle and exclusivity properties. The stimulus respects this rule. It changes mode and role only after several idle cycles. It drives `sck_in` and `baud_tick` only on falling clock edges, and it lets each slave edge drain before the next change.

// File: rtl/spi_edge_pkg.sv
package spi_edge_pkg;

    // Master clock state machine states
    typedef enum logic [0:0] {
        M_IDLE = 1'b0,
        M_RUN  = 1'b1
    } mst_state_t;

    // Edge kind reported by either path, before phase mapping
    typedef struct packed {
        logic lead;
        logic trail;
    } edge_pair_t;

endpackage

// File: rtl/spi_sck_master.sv
module spi_sck_master
    import spi_edge_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpol,
    input  logic       start,
    input  logic       baud_tick,
    output logic       sck,
    output logic       idle,
    output edge_pair_t edges
);
    localparam int HALVES = 2 * BITS;
    localparam int CW     = (HALVES > 2) ? $clog2(HALVES) : 1;
    localparam logic [CW-1:0] LAST_HALF = CW'(HALVES - 1);

    mst_state_t    state_q, state_d;
    logic [CW-1:0] half_q;
    logic          phase_q;
    logic          lead_q, trail_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE: if (start)                            state_d = M_RUN;
            M_RUN:  if (baud_tick && half_q == LAST_HALF) state_d = M_IDLE;
            default:                                      state_d = M_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            phase_q <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            unique case (state_q)
                M_IDLE: begin
                    half_q  <= '0;
                    phase_q <= 1'b0;
                end
                M_RUN: begin
                    if (baud_tick) begin
                        phase_q <= ~phase_q;
                        half_q  <= half_q + 1'b1;
                        if (!phase_q) lead_q  <= 1'b1;
                        else          trail_q <= 1'b1;
                    end
                end
                default: begin
                    half_q  <= '0;
                    phase_q <= 1'b0;
                end
            endcase
        end
    end

    assign sck         = cpol ^ phase_q;
    assign idle        = (state_q == M_IDLE);
    assign edges.lead  = lead_q;
    assign edges.trail = trail_q;

endmodule

// File: rtl/spi_sck_slave.sv
module spi_sck_slave
    import spi_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpol,
    input  logic       sck_in,
    output edge_pair_t edges
);
    localparam int FILL   = SYNC_STAGES + 1;
    localparam int FW     = $clog2(FILL + 1);
    localparam logic [FW-1:0] FILL_MAX = FW'(FILL);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [FW-1:0]          fill_q;
    logic                   armed;
    logic                   cur;

    genvar g;
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= sck_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            fill_q <= '0;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
            if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
        end
    end

    // Edges are trusted only once the pipeline holds real samples
    assign armed       = (fill_q == FILL_MAX);
    assign cur         = sync_q[SYNC_STAGES-1];
    assign edges.lead  = armed && (prev_q == cpol) && (cur != cpol);
    assign edges.trail = armed && (prev_q != cpol) && (cur == cpol);

endmodule

// File: rtl/spi_strobe_select.sv
module spi_strobe_select
    import spi_edge_pkg::*;
(
    input  logic       role_mst,
    input  logic       cpha,
    input  edge_pair_t mst_edges,
    input  edge_pair_t slv_edges,
    output logic       shift_stb,
    output logic       sample_stb,
    output logic       count_tick
);
    edge_pair_t pick;

    always_comb begin
        pick       = role_mst ? mst_edges : slv_edges;
        shift_stb  = cpha ? pick.lead  : pick.trail;
        sample_stb = cpha ? pick.trail : pick.lead;
        count_tick = pick.trail;
    end

endmodule

// File: rtl/spi_edge_gen.sv
module spi_edge_gen
    import spi_edge_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic role_mst,
    input  logic cpol,
    input  logic cpha,
    input  logic start,
    input  logic baud_tick,
    input  logic sck_in,
    output logic sck_out,
    output logic shift_stb,
    output logic sample_stb,
    output logic count_tick
);
    edge_pair_t mst_edges, slv_edges;
    logic       mst_idle;

    spi_sck_master #(.BITS(BITS)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (cpol),
        .start     (start & role_mst),
        .baud_tick (baud_tick),
        .sck       (sck_out),
        .idle      (mst_idle),
        .edges     (mst_edges)
    );

    spi_sck_slave #(.SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpol   (cpol),
        .sck_in (sck_in),
        .edges  (slv_edges)
    );

    spi_strobe_select u_select (
        .role_mst   (role_mst),
        .cpha       (cpha),
        .mst_edges  (mst_edges),
        .slv_edges  (slv_edges),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .count_tick (count_tick)
    );

endmodule

// File: rtl/spi_edge_gen_chk.sv
module spi_edge_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic role_mst,
    input logic cpol,
    input logic cpha,
    input logic mst_idle,
    input logic sck_out,
    input logic shift_stb,
    input logic sample_stb,
    input logic count_tick
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_stb && sample_stb)); // R6

    AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> !shift_stb); // R6

    AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R6

    AST_COUNT_ON_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        count_tick |-> (cpha ? sample_stb : shift_stb)); // R9

    AST_IDLE_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        mst_idle |-> (sck_out == cpol)); // R2

    AST_TOGGLE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (role_mst && $stable(role_mst) && $stable(cpol) && !$stable(sck_out))
            |-> (shift_stb || sample_stb)); // R4

endmodule

bind spi_edge_gen spi_edge_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_mst   (role_mst),
    .cpol       (cpol),
    .cpha       (cpha),
    .mst_idle   (mst_idle),
    .sck_out    (sck_out),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .count_tick (count_tick)
);

// File: tb/spi_edge_gen_tb.sv
module spi_edge_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    // {cpol, cpha, from_level, exp_shift, exp_sample, exp_count}
    localparam logic [5:0] SLV_VEC [8] = '{
        6'b000_010, 6'b001_101, 6'b010_100, 6'b011_011,
        6'b101_010, 6'b100_101, 6'b111_100, 6'b110_011
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic role_mst = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic start = 1'b0, baud_tick = 1'b0, sck_in = 1'b0;
    logic sck_out, shift_stb, sample_stb, count_tick;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_edge_gen u_dut (
        .clk(clk), .rst_n(rst_n), .role_mst(role_mst), .cpol(cpol),
        .cpha(cpha), .start(start), .baud_tick(baud_tick), .sck_in(sck_in),
        .sck_out(sck_out), .shift_stb(shift_stb), .sample_stb(sample_stb),
        .count_tick(count_tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, {shift_stb, sample_stb, count_tick}, 3'b000);
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic run_master(input logic pol, input logic pha, input bit mid_start);
        int ticks;
        ticks = 0;
        role_mst = 1'b1; cpol = pol; cpha = pha;
        idle_cycles(3);
        chk("R2 idle level", sck_out, pol);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            baud_tick = 1'b1;
            if (mid_start && i == 5) start = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            start = 1'b0;
            chk("R2 toggle", sck_out, pol ^ ((i + 1) % 2 == 1));
            if (i % 2 == 0)
                chk("R5 R4 leading edge strobes", {shift_stb, sample_stb, count_tick},
                    pha ? 3'b100 : 3'b010);
            else
                chk("R5 R4 trailing edge strobes", {shift_stb, sample_stb, count_tick},
                    pha ? 3'b011 : 3'b101);
            if (count_tick) ticks++;
            @(negedge clk);
            chk_quiet("R6 one-cycle strobe");
        end
        chk("R9 count ticks per transfer", ticks, 8);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        chk(mid_start ? "R11 no restart" : "R3 stop after 16", sck_out, pol);
        chk_quiet("R3 no strobe after end");
        idle_cycles(2);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, sck_in high to provoke a false edge
        sck_in = 1'b1;
        @(negedge clk);
        chk("R1 reset sck_out", sck_out, 1'b0);
        chk_quiet("R1 reset strobes");
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk_quiet("R1 no edge after release");
        end
        sck_in = 1'b0;
        idle_cycles(5);

        // Slave edge vector table: R7 R8 R5
        role_mst = 1'b0;
        for (int v = 0; v < 8; v++) begin
            cpol   = SLV_VEC[v][5];
            cpha   = SLV_VEC[v][4];
            sck_in = SLV_VEC[v][3];
            idle_cycles(5);
            chk_quiet("R7 settled");
            sck_in = ~SLV_VEC[v][3];
            @(posedge clk);
            chk_quiet("R7 no strobe before second edge");
            @(posedge clk);
            @(negedge clk);
            chk("R8 R5 slave edge strobes", {shift_stb, sample_stb, count_tick},
                SLV_VEC[v][2:0]);
            @(negedge clk);
            chk_quiet("R6 slave one-cycle");
        end
        sck_in = 1'b0;
        cpol = 1'b0;
        idle_cycles(5);

        // Slave role ignores start and baud ticks: R10
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            chk("R10 slave sck_out held", sck_out, 1'b0);
            chk_quiet("R10 slave ignores baud");
        end

        // Master transfers in all four modes: R2 R3 R4 R5 R9
        run_master(1'b0, 1'b0, 1'b0);
        run_master(1'b0, 1'b1, 1'b0);
        run_master(1'b1, 1'b0, 1'b0);
        run_master(1'b1, 1'b1, 1'b1);

        // Master role ignores sck_in: R10
        cpol = 1'b0; cpha = 1'b0;
        idle_cycles(3);
        for (int k = 0; k < 3; k++) begin
            sck_in = ~sck_in;
            repeat (3) begin
                @(negedge clk);
                chk_quiet("R10 master ignores sck_in");
            end
        end
        sck_in = 1'b0;
        idle_cycles(4);

        // Start during transfer with cpol=0: R11
        run_master(1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule